// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a small stored-program processor. It fetches and executes one instruction at a time, moving words between a program counter, a memory address register, a memory buffer register, an instruction register and a sixteen-entry, 32-bit register file. One control state machine sequences every transfer. Instruction fetch and data access share a single synchronous, word-addressed memory port. A multiplexer in front of the memory address register selects either the program counter or the instruction's address field.

The instruction word uses four fields. Bits [31:28] hold the opcode, [27:24] the destination (or, for a store, the source) register, [23:20] the first operand register and [19:16] the second operand register. Bits [15:0] hold a word-aligned byte address, used as a data address or as a branch target.

The memory port works as follows. A request on `mem_re` returns the addressed word on `mem_rdata` from the next cycle onward, and the word stays there until the next request. `mem_we` writes `mem_wdata` in the cycle it is high.

The state machine has these states:
- `ST_F_ADDR` loads the address register from the PC, and `ST_F_INC` adds 4 to the PC while it issues the read.
- `ST_F_READ` captures the memory word into the buffer register.
- `ST_F_IR` copies the buffer into the instruction register.
- `ST_DISPATCH` branches on the opcode.
- A load runs through `ST_LD_ADDR`, `ST_LD_REQ`, `ST_LD_CAP` and `ST_LD_WB`.
- A store runs through `ST_ST_ADDR` and `ST_ST_WR`.
- `ST_ALU` serves the four arithmetic opcodes, and `ST_BRANCH` serves the three branch opcodes.

Each of these paths returns to `ST_F_ADDR`. `ST_DISPATCH` also goes back to `ST_F_ADDR` for an undefined opcode. The halt opcode goes to `ST_HALT`, which never exits except through reset.

Top module: `seqcore_top`

## Requirements
- R1: While reset is held, and right after it, `done`, `mem_re` and `mem_we` are low, the PC is 0 and both flags are clear. The first memory read after reset goes to word address 0.
- R2: Each instruction is fetched in the order: address register from PC, PC plus 4 together with the read, buffer capture, then instruction register. Every fetch and every load issues exactly one `mem_re`.
- R3: Opcode 1 (load) writes the memory word at byte address [15:0] into the register named by [27:24].
- R4: Opcode 2 (store) writes the register named by [27:24] to the memory word at byte address [15:0], with one `mem_we` pulse. `mem_re` and `mem_we` are never high together.
- R5: Opcodes 3 (add) and 4 (subtract) write Rn+Rm or Rn-Rm (modulo 2^32) to Rd. They make no memory access during execute and leave the flags unchanged.
- R6: Opcodes 5 (add, set flags) and 6 (subtract, set flags) write the same results as R5. They also set Z when the result is zero and N to result bit 31.
- R7: Opcode 7 always replaces the PC with field [15:0], so execution continues at that byte address.
- R8: Opcode 8 branches only when Z is set, and opcode 9 branches only when N is clear. An untaken branch continues with the next instruction.
- R9: The flags keep their value across loads, stores, branches, plain add and subtract, and undefined opcodes.
- R10: Opcode 15 raises `done`, which then stays high. No further `mem_re` or `mem_we` occurs.
- R11: Opcodes 0 and 10 to 14 are undefined. They change no register, flag or memory word, and fetching continues.
- R12: `mem_addr` is the byte address in the address register shifted right by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | PC_W-2 | Word address of the shared memory port |
| mem_re | output | 1 | Read request; data returns from the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Read data, held until the next read |
| done | output | 1 | Halt reached |

## Verification
The assertions take three things for granted about the inputs:
- The memory holds read data steady from the cycle after a request until the next one.
- Every load, store and branch address in a program is a multiple of four.
- No program branches into its data area.

The bench memory model updates on the falling edge, so it returns data in exactly that way. The bench builds every program from fixed templates whose data words sit at aligned addresses above the code. It varies only the operand values, the arithmetic opcode and the branch kind at random. This keeps every run within those assumptions.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

    localparam int OPC_W  = 4;
    localparam int RIDX_W = 4;
    localparam int AFLD_W = 16;

    localparam logic [OPC_W-1:0] OP_LDR  = 4'd1;
    localparam logic [OPC_W-1:0] OP_STR  = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD  = 4'd3;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'd4;
    localparam logic [OPC_W-1:0] OP_ADDS = 4'd5;
    localparam logic [OPC_W-1:0] OP_SUBS = 4'd6;
    localparam logic [OPC_W-1:0] OP_B    = 4'd7;
    localparam logic [OPC_W-1:0] OP_BEQ  = 4'd8;
    localparam logic [OPC_W-1:0] OP_BPL  = 4'd9;
    localparam logic [OPC_W-1:0] OP_HALT = 4'd15;

    typedef enum logic [3:0] {
        ST_F_ADDR, ST_F_INC, ST_F_READ, ST_F_IR, ST_DISPATCH,
        ST_LD_ADDR, ST_LD_REQ, ST_LD_CAP, ST_LD_WB,
        ST_ST_ADDR, ST_ST_WR, ST_ALU, ST_BRANCH, ST_HALT
    } state_e;

    typedef struct packed {
        logic mar_ld;
        logic mar_sel_pc;
        logic pc_inc;
        logic pc_ld_tgt;
        logic mem_re;
        logic mem_we;
        logic mbr_ld;
        logic ir_ld;
        logic rf_we;
        logic rf_src_alu;
        logic flag_we;
        logic done;
    } ctrl_t;

endpackage

// File: rtl/seqcore_ctrl.sv
module seqcore_ctrl
    import seqcore_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc,
    input  logic             zf,
    input  logic             nf,
    output state_e           state,
    output ctrl_t            ctl
);

    state_e state_q, state_d;
    logic   taken;

    assign state = state_q;
    assign taken = (opc == OP_B) || ((opc == OP_BEQ) && zf) || ((opc == OP_BPL) && !nf);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_F_ADDR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_F_ADDR:   state_d = ST_F_INC;
            ST_F_INC:    state_d = ST_F_READ;
            ST_F_READ:   state_d = ST_F_IR;
            ST_F_IR:     state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                if (opc == OP_LDR)                         state_d = ST_LD_ADDR;
                else if (opc == OP_STR)                    state_d = ST_ST_ADDR;
                else if (opc >= OP_ADD && opc <= OP_SUBS)  state_d = ST_ALU;
                else if (opc >= OP_B && opc <= OP_BPL)     state_d = ST_BRANCH;
                else if (opc == OP_HALT)                   state_d = ST_HALT;
                else                                       state_d = ST_F_ADDR;
            end
            ST_LD_ADDR:  state_d = ST_LD_REQ;
            ST_LD_REQ:   state_d = ST_LD_CAP;
            ST_LD_CAP:   state_d = ST_LD_WB;
            ST_LD_WB:    state_d = ST_F_ADDR;
            ST_ST_ADDR:  state_d = ST_ST_WR;
            ST_ST_WR:    state_d = ST_F_ADDR;
            ST_ALU:      state_d = ST_F_ADDR;
            ST_BRANCH:   state_d = ST_F_ADDR;
            ST_HALT:     state_d = ST_HALT;
            default:     state_d = ST_F_ADDR;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_F_ADDR:  begin ctl.mar_ld = 1'b1; ctl.mar_sel_pc = 1'b1; end
            ST_F_INC:   begin ctl.pc_inc = 1'b1; ctl.mem_re = 1'b1; end
            ST_F_READ:  ctl.mbr_ld = 1'b1;
            ST_F_IR:    ctl.ir_ld = 1'b1;
            ST_LD_ADDR: ctl.mar_ld = 1'b1;
            ST_LD_REQ:  ctl.mem_re = 1'b1;
            ST_LD_CAP:  ctl.mbr_ld = 1'b1;
            ST_LD_WB:   ctl.rf_we = 1'b1;
            ST_ST_ADDR: ctl.mar_ld = 1'b1;
            ST_ST_WR:   ctl.mem_we = 1'b1;
            ST_ALU: begin
                ctl.rf_we      = 1'b1;
                ctl.rf_src_alu = 1'b1;
                ctl.flag_we    = (opc == OP_ADDS) || (opc == OP_SUBS);
            end
            ST_BRANCH:  ctl.pc_ld_tgt = taken;
            ST_HALT:    ctl.done = 1'b1;
            default:    ctl = '0;
        endcase
    end

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.done |=> ctl.done);

    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_re && ctl.mem_we));

endmodule

// File: rtl/seqcore_regfile.sv
module seqcore_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] ra_addr,
    output logic [DW-1:0]           ra_data,
    input  logic [$clog2(NREG)-1:0] rb_addr,
    output logic [DW-1:0]           rb_data
);

    localparam int AW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           regs[g] <= '0;
            else if (we && waddr == AW'(g))       regs[g] <= wdata;
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

endmodule

// File: rtl/seqcore_alu.sv
module seqcore_alu #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y,
    output logic          z,
    output logic          n
);

    assign y = sub ? (a - b) : (a + b);
    assign z = (y == '0);
    assign n = y[DW-1];

endmodule

// File: rtl/seqcore_top.sv
module seqcore_top
    import seqcore_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-3:0] mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            done
);

    localparam int RA_W = $clog2(NREG);

    state_e           state;
    ctrl_t            ctl;
    logic [PC_W-1:0]  pc, mar, mar_next;
    logic [DW-1:0]    mbr, ir;
    logic             zf, nf;
    logic [OPC_W-1:0] opc;
    logic [RA_W-1:0]  rd, rn, rm, ra_sel;
    logic [PC_W-1:0]  addr_fld;
    logic [DW-1:0]    ra_data, rb_data, alu_y, rf_wdata;
    logic             alu_sub, alu_z, alu_n;

    assign opc      = ir[DW-1 -: OPC_W];
    assign rd       = ir[DW-OPC_W-1 -: RA_W];
    assign rn       = ir[DW-OPC_W-RIDX_W-1 -: RA_W];
    assign rm       = ir[DW-OPC_W-2*RIDX_W-1 -: RA_W];
    assign addr_fld = ir[PC_W-1:0];

    seqcore_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .opc(opc), .zf(zf), .nf(nf),
        .state(state), .ctl(ctl)
    );

    // store reads its source through the same port as the first operand
    assign ra_sel = (opc == OP_STR) ? rd : rn;

    seqcore_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(ctl.rf_we), .waddr(rd), .wdata(rf_wdata),
        .ra_addr(ra_sel), .ra_data(ra_data), .rb_addr(rm), .rb_data(rb_data)
    );

    assign alu_sub = (opc == OP_SUB) || (opc == OP_SUBS);

    seqcore_alu #(.DW(DW)) u_alu (
        .a(ra_data), .b(rb_data), .sub(alu_sub), .y(alu_y), .z(alu_z), .n(alu_n)
    );

    assign rf_wdata = ctl.rf_src_alu ? alu_y : mbr;

    // address multiplexer: program counter for fetch, address field for data
    assign mar_next = ctl.mar_sel_pc ? pc : addr_fld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            zf  <= 1'b0;
            nf  <= 1'b0;
        end else begin
            if (ctl.mar_ld)         mar <= mar_next;
            if (ctl.pc_inc)         pc  <= pc + PC_W'(4);
            else if (ctl.pc_ld_tgt) pc  <= addr_fld;
            if (ctl.mbr_ld)         mbr <= mem_rdata;
            if (ctl.ir_ld)          ir  <= mbr;
            if (ctl.flag_we) begin
                zf <= alu_z;
                nf <= alu_n;
            end
        end
    end

    assign mem_addr  = mar[PC_W-1:2];
    assign mem_re    = ctl.mem_re;
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = ra_data;
    assign done      = ctl.done;

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_INC) |=> (pc == $past(pc) + PC_W'(4)));

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.flag_we |=> $stable({zf, nf}));

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_re && !mem_we));

    a_r12_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (mar[1:0] == 2'b00));

    a_r7_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld_tgt |-> (addr_fld[1:0] == 2'b00));

endmodule

// File: tb/seqcore_top_tb_top.sv
`timescale 1ns/1ps
module seqcore_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mem_addr;
    logic        mem_re, mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [0:1023];
    int          rd_cnt;
    bit          first_rd;
    logic [13:0] first_addr;

    localparam logic [31:0] INIT_Y = 32'hDEAD_BEEF;

    always #4 clk = ~clk;

    seqcore_top dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    always @(negedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
        if (mem_re) begin
            mem_rdata = mem[mem_addr[9:0]];
            rd_cnt++;
            if (first_rd) begin
                first_addr = mem_addr;
                first_rd   = 1'b0;
            end
        end
    end

    function automatic logic [31:0] enc(int op, int rd, int rn, int rm, int addr);
        logic [3:0] o, d, a, b;
        logic [15:0] f;
        o = op[3:0]; d = rd[3:0]; a = rn[3:0]; b = rm[3:0]; f = addr[15:0];
        return {o, d, a, b, f};
    endfunction

    function automatic logic [31:0] alu_model(int op, logic [31:0] a, logic [31:0] b);
        return (op == 4 || op == 6) ? a - b : a + b;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'hF000_0000;
    endtask

    task automatic run_prog(output bit finished, output bit quiet);
        finished = 1'b0;
        quiet    = 1'b1;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rd_cnt   = 0;
        first_rd = 1'b1;
        rst_n    = 1'b1;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (done) begin
                finished = 1'b1;
                break;
            end
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (mem_re || mem_we || !done) quiet = 1'b0;
        end
    endtask

    // data words: A/P at 0x200, B/Q at 0x204, X at 0x208, K/C20 at 0x20C, Y/C5 at 0x210
    task automatic pq_case(logic [31:0] p, logic [31:0] q);
        bit fin, qt, tk;
        logic [31:0] diff, exp;
        clear_mem();
        mem[0]  = enc(1, 0, 0, 0, 'h200);
        mem[1]  = enc(1, 1, 0, 0, 'h204);
        mem[2]  = enc(1, 5, 0, 0, 'h20C);
        mem[3]  = enc(1, 6, 0, 0, 'h210);
        mem[4]  = enc(6, 2, 0, 1, 0);
        mem[5]  = enc(9, 0, 0, 0, 'h20);
        mem[6]  = enc(3, 0, 0, 5, 0);
        mem[7]  = enc(7, 0, 0, 0, 'h24);
        mem[8]  = enc(3, 0, 0, 6, 0);
        mem[9]  = enc(2, 0, 0, 0, 'h208);
        mem[128] = p; mem[129] = q; mem[130] = 0; mem[131] = 20; mem[132] = 5;
        run_prog(fin, qt);
        diff = p - q;
        tk   = !diff[31];
        exp  = tk ? p + 5 : p + 20;
        check(fin, "R10 halt reached", {31'd0, done}, 32'd1);
        check(mem[130] == exp, "R8 BPL select / R3 load / R4 store", mem[130], exp);
        check(rd_cnt == (tk ? 13 : 14), "R2 read count", rd_cnt, tk ? 13 : 14);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit fin, qt;
        void'($urandom(32'd7321));

        // R1 reset state
        clear_mem();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!done && !mem_re && !mem_we, "R1 outputs in reset",
              {29'd0, done, mem_re, mem_we}, 32'd0);

        // R1 first fetch address, R10 halt only program
        run_prog(fin, qt);
        check(first_addr == 14'd0, "R1 first fetch word", {18'd0, first_addr}, 32'd0);
        check(fin && qt, "R10 halt quiet and sticky", {30'd0, fin, qt}, 32'd3);
        check(rd_cnt == 1, "R2 single fetch before halt", rd_cnt, 1);

        // directed branch-on-plus cases incl. equal and overflow boundary
        pq_case(32'd12, 32'd9);
        pq_case(32'd3, 32'd9);
        pq_case(32'd77, 32'd77);
        pq_case(32'h8000_0000, 32'd1);

        // R7, R9, R5: flags survive load/add/store/branch; B skips a store
        clear_mem();
        mem[0]  = enc(1, 1, 0, 0, 'h200);
        mem[1]  = enc(1, 2, 0, 0, 'h204);
        mem[2]  = enc(6, 3, 1, 1, 0);
        mem[3]  = enc(1, 4, 0, 0, 'h200);
        mem[4]  = enc(3, 5, 1, 2, 0);
        mem[5]  = enc(2, 5, 0, 0, 'h208);
        mem[6]  = enc(7, 0, 0, 0, 'h20);
        mem[7]  = enc(2, 1, 0, 0, 'h210);
        mem[8]  = enc(8, 0, 0, 0, 'h28);
        mem[9]  = enc(2, 2, 0, 0, 'h210);
        mem[128] = 32'h0000_1111; mem[129] = 32'h0000_2222; mem[130] = 0; mem[132] = INIT_Y;
        run_prog(fin, qt);
        check(mem[130] == 32'h3333, "R5 plain add result", mem[130], 32'h3333);
        check(mem[132] == INIT_Y, "R7/R9 B skip and Z kept for BEQ", mem[132], INIT_Y);

        // R11 undefined opcode is a no-op
        clear_mem();
        mem[0] = enc(1, 1, 0, 0, 'h200);
        mem[1] = enc(10, 1, 2, 3, 'h204);
        mem[2] = enc(0, 1, 1, 1, 'h208);
        mem[3] = enc(2, 1, 0, 0, 'h208);
        mem[128] = 32'hCAFE_0001; mem[129] = 32'h5; mem[130] = 0;
        run_prog(fin, qt);
        check(mem[130] == 32'hCAFE_0001, "R11 undefined opcode no-op", mem[130], 32'hCAFE_0001);
        check(mem[129] == 32'h5, "R11 memory untouched", mem[129], 32'h5);

        // random arithmetic and conditional branches (R5 R6 R8 R9 R12)
        for (int it = 0; it < 40; it++) begin
            int op, br;
            logic [31:0] a, b, res;
            bit zx, nx, tk;
            op = 3 + int'($urandom_range(0, 3));
            br = 8 + int'($urandom_range(0, 1));
            a  = $urandom();
            case ($urandom_range(0, 3))
                0: b = a;
                1: b = 32'hFFFF_FFFF;
                default: b = $urandom();
            endcase
            clear_mem();
            mem[0] = enc(1, 1, 0, 0, 'h200);
            mem[1] = enc(1, 2, 0, 0, 'h204);
            mem[2] = enc(1, 7, 0, 0, 'h20C);
            mem[3] = enc(op, 3, 1, 2, 0);
            mem[4] = enc(2, 3, 0, 0, 'h208);
            mem[5] = enc(br, 0, 0, 0, 'h1C);
            mem[6] = enc(2, 1, 0, 0, 'h210);
            mem[128] = a; mem[129] = b; mem[130] = 0; mem[131] = 32'h1; mem[132] = INIT_Y;
            run_prog(fin, qt);
            res = alu_model(op, a, b);
            zx  = (op >= 5) ? (res == 0) : 1'b0;
            nx  = (op >= 5) ? res[31] : 1'b0;
            tk  = (br == 8) ? zx : !nx;
            check(mem[130] == res, (op >= 5) ? "R6 flag-setting result" : "R5 plain result",
                  mem[130], res);
            check(mem[132] == (tk ? INIT_Y : a), "R8/R9 conditional branch on flags",
                  mem[132], tk ? INIT_Y : a);
            check(rd_cnt == (tk ? 10 : 11), "R12 read count", rd_cnt, tk ? 10 : 11);
            check(fin && qt, "R10 done sticky", {30'd0, fin, qt}, 32'd3);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule